// File: doc/BRIEF.md
# Password-Guarded Flash Block Lock Register

This block is a single memory-mapped register that decides which groups of flash blocks are shielded from program and erase. The lock bits come in three ranges: low, mid and small. After reset they hold a configuration word that is sampled while reset is asserted. That word stands in for nonvolatile shadow data, so an erased (all-ones) word leaves every block locked.

Software cannot change the lock bits until it writes one fixed 32-bit key to the register. Writing the key raises a read-only enable flag. The flag stays high until the next reset, and no register write can clear it. While the flag is low, every write to the register is dropped without any error.

The inhibit output for each block is the OR of that block's bit in this register and the matching bit of a secondary lock register that sits outside this block. The register bus is a write strobe with write data, plus a read data path that reflects the current state combinationally.

Top module: `blk_lock_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, read bit 31 (the enable flag) is 0.
- R2: During reset the lock vector loads `cfg_word`. Vector bits 5:0 are the low locks, read at bits 5:0. Vector bits 7:6 are the mid locks, read at bits 9:8. Vector bits 11:8 are the small locks, read at bits 19:16. An all-ones word locks every block.
- R3: A write (`reg_we`=1) of exactly 0xA1A11111 sets the enable flag, and the flag is visible on the read data one cycle after the write edge. No other write sets it, and the key does nothing when `reg_we` is 0.
- R4: Once set, the enable flag stays at 1 until reset, including after writes that carry 0 in bit 31.
- R5: While the enable flag is 0, any write leaves every read data bit unchanged, and no error is signalled.
- R6: While the enable flag is 1, a write of any value other than the key replaces all lock bits with the write data bits at the positions given in R2.
- R7: A write of the key value never modifies the lock bits, whether the flag was 0 or 1.
- R8: Read bits outside bit 31 and the lock fields of R2 always read 0, whatever was written.
- R9: `inhibit[i]` equals lock vector bit i OR `sec_lock[i]`, combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 12 | Shadow configuration word, sampled during reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data: enable flag and lock fields |
| sec_lock | input | 12 | Secondary lock register bits, ordered like the lock vector |
| inhibit | output | 12 | Per-block program/erase inhibit |

## Verification
The hardest case to reach from the ports is a key write that arrives after the flag is already set. The key carries non-zero data inside every lock field, so a design that let it through as an ordinary write would visibly change the locks. The stimulus reaches this case by first unlocking, then loading a known pattern, and only then writing the key again. The bench also runs reset with several shadow words, and checks that the flag survives writes whose bit 31 is 0 but that it does not survive a second reset.

// File: rtl/lk_pkg.sv
package lk_pkg;

   localparam int LK_DW = 32;
   localparam int LK_FLAG_BIT = LK_DW - 1;

   typedef struct packed {
      logic             we;
      logic [LK_DW-1:0] data;
   } lk_wr_t;

   function automatic logic lk_key_hit(input lk_wr_t wr, input logic [LK_DW-1:0] key);
      return wr.we && (wr.data == key);
   endfunction

endpackage

// File: rtl/lk_key_gate.sv
module lk_key_gate
   import lk_pkg::*;
#(
   parameter logic [LK_DW-1:0] KEY = 32'hA1A1_1111
) (
   input  logic   clk,
   input  logic   rst_n,
   input  lk_wr_t wr,
   output logic   key_hit,
   output logic   unlocked
);

   assign key_hit = lk_key_hit(wr, KEY);

   always_ff @(posedge clk) begin
      if (!rst_n)       unlocked <= 1'b0;
      else if (key_hit) unlocked <= 1'b1;
   end

endmodule

// File: rtl/lk_field_bank.sv
module lk_field_bank #(
   parameter int LOCK_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LOCK_W-1:0] shadow,
   input  logic              upd,
   input  logic [LOCK_W-1:0] upd_val,
   output logic [LOCK_W-1:0] lock_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)   lock_q <= shadow;
      else if (upd) lock_q <= upd_val;
   end

endmodule

// File: rtl/lk_merge.sv
module lk_merge #(
   parameter int LOCK_W = 12
) (
   input  logic [LOCK_W-1:0] own_lock,
   input  logic [LOCK_W-1:0] other_lock,
   output logic [LOCK_W-1:0] inhibit
);

   for (genvar i = 0; i < LOCK_W; i++) begin : g_or
      assign inhibit[i] = own_lock[i] | other_lock[i];
   end

endmodule

// File: rtl/blk_lock_reg.sv
module blk_lock_reg
   import lk_pkg::*;
#(
   parameter int               LOW_W     = 6,
   parameter int               MID_W     = 2,
   parameter int               SMALL_W   = 4,
   parameter int               LOW_LSB   = 0,
   parameter int               MID_LSB   = 8,
   parameter int               SMALL_LSB = 16,
   parameter logic [LK_DW-1:0] KEY       = 32'hA1A1_1111,
   localparam int              LOCK_W    = LOW_W + MID_W + SMALL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LOCK_W-1:0] cfg_word,
   input  logic              reg_we,
   input  logic [LK_DW-1:0]  reg_wdata,
   output logic [LK_DW-1:0]  reg_rdata,
   input  logic [LOCK_W-1:0] sec_lock,
   output logic [LOCK_W-1:0] inhibit
);

   localparam int MID_BASE   = LOW_W;
   localparam int SMALL_BASE = LOW_W + MID_W;

   // elaboration-time layout checks
   if (LOW_W < 1 || MID_W < 1 || SMALL_W < 1) begin : g_bad_width
      initial $fatal(1, "blk_lock_reg: every lock field needs at least one bit");
   end
   if (LOW_LSB + LOW_W > MID_LSB || MID_LSB + MID_W > SMALL_LSB) begin : g_bad_order
      initial $fatal(1, "blk_lock_reg: lock fields overlap");
   end
   if (SMALL_LSB + SMALL_W > LK_FLAG_BIT) begin : g_bad_top
      initial $fatal(1, "blk_lock_reg: lock fields collide with the enable flag");
   end

   lk_wr_t            wr;
   logic              key_hit;
   logic              unlocked;
   logic              upd;
   logic [LOCK_W-1:0] upd_val;
   logic [LOCK_W-1:0] lock_q;

   assign wr.we   = reg_we;
   assign wr.data = reg_wdata;

   lk_key_gate #(.KEY(KEY)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr),
      .key_hit  (key_hit),
      .unlocked (unlocked)
   );

   // the key itself never lands in the lock fields
   assign upd = reg_we && unlocked && !key_hit;

   // bus bit positions -> packed lock vector
   for (genvar i = 0; i < LOW_W; i++) begin : g_low_in
      assign upd_val[i] = reg_wdata[LOW_LSB + i];
   end
   for (genvar i = 0; i < MID_W; i++) begin : g_mid_in
      assign upd_val[MID_BASE + i] = reg_wdata[MID_LSB + i];
   end
   for (genvar i = 0; i < SMALL_W; i++) begin : g_small_in
      assign upd_val[SMALL_BASE + i] = reg_wdata[SMALL_LSB + i];
   end

   lk_field_bank #(.LOCK_W(LOCK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .shadow  (cfg_word),
      .upd     (upd),
      .upd_val (upd_val),
      .lock_q  (lock_q)
   );

   always_comb begin
      reg_rdata = '0;
      reg_rdata[LK_FLAG_BIT] = unlocked;
      for (int i = 0; i < LOW_W; i++)   reg_rdata[LOW_LSB + i]   = lock_q[i];
      for (int i = 0; i < MID_W; i++)   reg_rdata[MID_LSB + i]   = lock_q[MID_BASE + i];
      for (int i = 0; i < SMALL_W; i++) reg_rdata[SMALL_LSB + i] = lock_q[SMALL_BASE + i];
   end

   lk_merge #(.LOCK_W(LOCK_W)) u_merge (
      .own_lock   (lock_q),
      .other_lock (sec_lock),
      .inhibit    (inhibit)
   );

endmodule

// File: rtl/lk_checker.sv
module lk_checker
   import lk_pkg::*;
#(
   parameter int               LOW_W     = 6,
   parameter int               MID_W     = 2,
   parameter int               SMALL_W   = 4,
   parameter int               LOW_LSB   = 0,
   parameter int               MID_LSB   = 8,
   parameter int               SMALL_LSB = 16,
   parameter logic [LK_DW-1:0] KEY       = 32'hA1A1_1111,
   localparam int              LOCK_W    = LOW_W + MID_W + SMALL_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [LK_DW-1:0]  reg_wdata,
   input logic [LK_DW-1:0]  reg_rdata,
   input logic [LOCK_W-1:0] sec_lock,
   input logic [LOCK_W-1:0] inhibit
);

   logic [LK_DW-1:0]  used;
   logic [LOCK_W-1:0] seen;
   logic              is_key;

   assign is_key = reg_we && (reg_wdata == KEY);

   always_comb begin
      used = '0;
      seen = '0;
      used[LK_FLAG_BIT] = 1'b1;
      for (int i = 0; i < LOW_W; i++) begin
         used[LOW_LSB + i] = 1'b1;
         seen[i] = reg_rdata[LOW_LSB + i];
      end
      for (int i = 0; i < MID_W; i++) begin
         used[MID_LSB + i] = 1'b1;
         seen[LOW_W + i] = reg_rdata[MID_LSB + i];
      end
      for (int i = 0; i < SMALL_W; i++) begin
         used[SMALL_LSB + i] = 1'b1;
         seen[LOW_W + MID_W + i] = reg_rdata[SMALL_LSB + i];
      end
   end

   assert_flag_clear_R1: assert property (@(posedge clk) !rst_n |=> !reg_rdata[LK_FLAG_BIT]);

   assert_key_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_key |=> reg_rdata[LK_FLAG_BIT]);

   assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[LK_FLAG_BIT] |=> reg_rdata[LK_FLAG_BIT]);

   assert_locked_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[LK_FLAG_BIT] && !is_key |=> $stable(reg_rdata));

   assert_key_keeps_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_key |=> $stable(reg_rdata[LK_FLAG_BIT-1:0]));

   assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~used) == '0);

   assert_inhibit_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit == (seen | sec_lock));

endmodule

bind blk_lock_reg lk_checker #(
   .LOW_W(LOW_W), .MID_W(MID_W), .SMALL_W(SMALL_W),
   .LOW_LSB(LOW_LSB), .MID_LSB(MID_LSB), .SMALL_LSB(SMALL_LSB), .KEY(KEY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .sec_lock  (sec_lock),
   .inhibit   (inhibit)
);

// File: tb/sim_blk_lock_reg.sv
module sim_blk_lock_reg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_word = 12'hFFF;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [11:0] sec_lock = '0;
   logic [11:0] inhibit;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   blk_lock_reg u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_word  (cfg_word),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sec_lock  (sec_lock),
      .inhibit   (inhibit)
   );

   typedef struct packed {
      logic        we;
      logic [31:0] wd;
      logic [11:0] sec;
      logic [31:0] exp_rd;
      logic [11:0] exp_inh;
   } vec_t;

   // applied after a reset with cfg_word = 12'hFFF
   localparam vec_t VEC [8] = '{
      '{1'b1, 32'h0000_0000, 12'h000, 32'h000F_033F, 12'hFFF}, // R5 flag low, write dropped
      '{1'b1, 32'hA1A1_1111, 12'h000, 32'h800F_033F, 12'hFFF}, // R3 R7 key
      '{1'b1, 32'h0000_0000, 12'h000, 32'h8000_0000, 12'h000}, // R6 R4 clear all
      '{1'b1, 32'hFFFF_FFFF, 12'h000, 32'h800F_033F, 12'hFFF}, // R8 R6 all ones
      '{1'b1, 32'h0005_0102, 12'h000, 32'h8005_0102, 12'h542}, // R6 mixed
      '{1'b0, 32'h0000_0000, 12'h0A8, 32'h8005_0102, 12'h5EA}, // R9 secondary OR
      '{1'b1, 32'hA1A1_1111, 12'h000, 32'h8005_0102, 12'h542}, // R7 key with flag set
      '{1'b1, 32'h7FFF_FFFF, 12'h000, 32'h800F_033F, 12'hFFF}  // R4 bit31=0 write
   };
   localparam string TAG [8] = '{"R5", "R3", "R6", "R8", "R6", "R9", "R7", "R4"};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [11:0] cfg);
      @(negedge clk);
      rst_n = 1'b0; cfg_word = cfg; reg_we = 1'b0; sec_lock = '0;
      @(negedge clk);
      @(negedge clk);
      chk("R1 flag during reset", {31'd0, reg_rdata[31]}, 32'd0);
      rst_n = 1'b1;
      cfg_word = ~cfg;   // must be ignored after reset
   endtask

   task automatic wr(input logic [31:0] d);
      reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   initial begin
      do_reset(12'hFFF);
      chk("R1 flag after reset", {31'd0, reg_rdata[31]}, 32'd0);
      chk("R2 all-ones shadow", reg_rdata, 32'h000F_033F);
      chk("R2 all-ones inhibit", {20'd0, inhibit}, 32'h0000_0FFF);

      for (int k = 0; k < 8; k++) begin
         reg_we = VEC[k].we; reg_wdata = VEC[k].wd; sec_lock = VEC[k].sec;
         @(negedge clk);
         chk({TAG[k], " vec rdata"}, reg_rdata, VEC[k].exp_rd);
         chk({TAG[k], " vec inhibit"}, {20'd0, inhibit}, {20'd0, VEC[k].exp_inh});
      end
      reg_we = 1'b0; sec_lock = '0;

      // R1: reset drops the flag again
      do_reset(12'h000);
      @(negedge clk);
      chk("R1 flag cleared by reset", reg_rdata, 32'h0000_0000);
      chk("R2 zero shadow inhibit", {20'd0, inhibit}, 32'd0);

      // R2: mixed shadow word
      do_reset(12'hA5C);
      chk("R2 mixed shadow", reg_rdata, 32'h000A_011C);

      // R5: near-miss key and plain writes while locked
      wr(32'hA1A1_1110);
      chk("R5 near-miss key", reg_rdata, 32'h000A_011C);
      wr(32'h800F_0000);
      chk("R5 bit31 write while locked", reg_rdata, 32'h000A_011C);

      // R3: key on the data lines without the strobe
      reg_wdata = 32'hA1A1_1111;
      @(negedge clk);
      reg_wdata = '0;
      chk("R3 key without strobe", reg_rdata, 32'h000A_011C);

      // R3/R7: key from locked state keeps the mixed fields
      wr(32'hA1A1_1111);
      chk("R3 R7 unlock keeps fields", reg_rdata, 32'h800A_011C);
      wr(32'h0000_0001);
      chk("R6 single low bit", reg_rdata, 32'h8000_0001);
      chk("R9 single inhibit", {20'd0, inhibit}, 32'h0000_0001);
      sec_lock = 12'h800;
      #1;
      chk("R9 same-cycle secondary", {20'd0, inhibit}, 32'h0000_0801);
      sec_lock = '0;

      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule